// File: doc/BRIEF.md
# Bus Cycle Timeout and Double-Fault Halt Monitor

This block watches bus cycles that leave the internal bus for the external bus. It raises a one-clock bus error when such a cycle runs for a chosen number of system clocks without an acknowledge. The period is chosen from four values by a 2-bit field. The bus monitor enable and the period field each take a single write after reset, and later writes to them are dropped.

The block also tracks faults. A fault event is either the bus-fault input or the block's own bus error. Once one fault event has been seen, a second one before a clean acknowledge is a double fault. If the halt monitor is enabled at that point, halt goes high and stays high until reset.

Software sets these enables and the period through a small write-only register port with one write strobe per field.

Top module: `bushalt_mon`

## Requirements
- R1: A cycle is timed only if the bus monitor enable is 1 and `cyc_ext` is 1 in the clock where `cyc_start` is sampled. Any other cycle never produces a bus error. A `cyc_start` that arrives while a timed cycle is in progress is ignored.
- R2: The period field code 00, 01, 10 or 11 selects 64, 32, 16 or 8 clocks. With no acknowledge, `bus_err` goes high right after the N-th rising edge that follows the edge that sampled `cyc_start`, where N is the selected count.
- R3: `bus_err` is high for exactly one clock, and the timed cycle ends with it.
- R4: An acknowledge sampled on or before the N-th edge ends the cycle, and no bus error follows.
- R5: The bus monitor enable is `cfg_wdata[1]`, written when `cfg_wr_sel[1]` is 1. Only the first such write after reset takes effect.
- R6: The period field is `cfg_wdata[3:2]`, written when `cfg_wr_sel[2]` is 1. Only the first such write after reset takes effect. Its lock is separate from the enable's lock.
- R7: The halt monitor enable is `cfg_wdata[0]`, written when `cfg_wr_sel[0]` is 1. It can be rewritten at any time.
- R8: A fault event is a `bus_fault` pulse or a `bus_err` pulse. A second fault event while a fault is pending, with the halt monitor enabled, raises `halt` one clock later. `halt` then stays high until reset.
- R9: The pending fault clears on a clock with `cyc_ack` high and no fault event. While the halt monitor is disabled, no double fault raises halt, but the pending fault is still tracked.
- R10: After reset, `bus_err` and `halt` are 0, both enables are 0, the period code is 00, and both locks are open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | A bus cycle begins |
| cyc_ext | input | 1 | The starting cycle goes from the internal to the external bus |
| cyc_ack | input | 1 | The current cycle completed successfully |
| bus_fault | input | 1 | Bus-fault indication from elsewhere |
| cfg_wr_sel | input | 3 | Per-field write strobes: bit0 halt enable, bit1 bus monitor enable, bit2 period |
| cfg_wdata | input | 4 | Write data: bit0 halt enable, bit1 bus monitor enable, bits 3:2 period code |
| bus_err | output | 1 | One-clock bus error on timeout |
| halt | output | 1 | Sticky halt on a double fault |

## Verification
The bench places the acknowledge exactly on the terminal edge and one edge before it. A design with an off-by-one counter, or one that lets the timeout win that race, shows up as a spurious or shifted error. It also programs the enable and the period with separate first writes and then tries to overwrite each one. A design with a shared lock, or with no lock, would time the wrong period or start timing a cycle it should ignore. For the halt path, the bench turns the halt enable on only after the first fault and also clears a pending fault with a clean acknowledge. A design that forgets the pending fault while halt is disabled, or never clears it, would halt at the wrong time.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
  localparam int TSEL_W = 2;

  typedef struct packed {
    logic              halt_en;
    logic              bm_en;
    logic [TSEL_W-1:0] tsel;
  } bhm_cfg_t;

  // Each step of the period code halves the base period.
  function automatic int unsigned tmo_clocks(input int unsigned base,
                                             input logic [TSEL_W-1:0] code);
    return base >> code;
  endfunction
endpackage

// File: rtl/bhm_cfg_regs.sv
module bhm_cfg_regs
  import bhm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] wr_sel,
  input  logic [3:0] wdata,
  output bhm_cfg_t   cfg,
  output logic       bm_lock,
  output logic       tsel_lock
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      bm_lock   <= 1'b0;
      tsel_lock <= 1'b0;
    end else begin
      if (wr_sel[0]) cfg.halt_en <= wdata[0];
      if (wr_sel[1] && !bm_lock) begin
        cfg.bm_en <= wdata[1];
        bm_lock   <= 1'b1;
      end
      if (wr_sel[2] && !tsel_lock) begin
        cfg.tsel  <= wdata[3:2];
        tsel_lock <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bhm_cycle_timer.sv
module bhm_cycle_timer
  import bhm_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext,
  input  logic              ack,
  input  logic              bm_en,
  input  logic [TSEL_W-1:0] tsel,
  output logic              busy,
  output logic              tmo
);
  localparam int CNT_W = $clog2(BASE_PERIOD);
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] limit;
  logic             term;

  assign limit = LIM_W'(tmo_clocks(BASE_PERIOD, tsel));
  assign term  = ({1'b0, cnt} == (limit - LIM_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      tmo  <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (busy) begin
        if (ack) begin
          busy <= 1'b0;
        end else if (term) begin
          busy <= 1'b0;
          tmo  <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (start && ext && bm_en) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/bhm_fault_track.sv
module bhm_fault_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic tmo,
  input  logic ack,
  input  logic halt_en,
  output logic fault_ev,
  output logic pending,
  output logic halt
);
  logic dbl;

  assign fault_ev = fault_in | tmo;
  assign dbl      = fault_ev & pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      halt    <= 1'b0;
    end else begin
      if (fault_ev)  pending <= 1'b1;
      else if (ack)  pending <= 1'b0;
      if (dbl && halt_en) halt <= 1'b1;
    end
  end
endmodule

// File: rtl/bushalt_mon.sv
module bushalt_mon
  import bhm_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       cyc_ext,
  input  logic       cyc_ack,
  input  logic       bus_fault,
  input  logic [2:0] cfg_wr_sel,
  input  logic [3:0] cfg_wdata,
  output logic       bus_err,
  output logic       halt
);
  bhm_cfg_t cfg_q;
  logic     bm_lock, tsel_lock;
  logic     busy_w, tmo_w, fault_ev_w, pending_w;

  bhm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_sel(cfg_wr_sel), .wdata(cfg_wdata),
    .cfg(cfg_q), .bm_lock(bm_lock), .tsel_lock(tsel_lock)
  );

  bhm_cycle_timer #(.BASE_PERIOD(BASE_PERIOD)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .ext(cyc_ext),
    .ack(cyc_ack), .bm_en(cfg_q.bm_en), .tsel(cfg_q.tsel),
    .busy(busy_w), .tmo(tmo_w)
  );

  bhm_fault_track u_flt (
    .clk(clk), .rst_n(rst_n), .fault_in(bus_fault), .tmo(tmo_w),
    .ack(cyc_ack), .halt_en(cfg_q.halt_en), .fault_ev(fault_ev_w),
    .pending(pending_w), .halt(halt)
  );

  assign bus_err = tmo_w;
endmodule

// File: rtl/bushalt_mon_chk.sv
module bushalt_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_err,
  input logic       halt,
  input logic       busy,
  input logic       cyc_ack,
  input logic       halt_en,
  input logic       bm_en,
  input logic [1:0] tsel,
  input logic       bm_lock,
  input logic       tsel_lock,
  input logic       pending,
  input logic       fault_ev
);
  a_r1_err_needs_timed_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(busy));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
  a_r4_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_ack) |=> !bus_err);
  a_r5_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    bm_lock |=> $stable(bm_en));
  a_r6_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
    tsel_lock |=> $stable(tsel));
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r8_halt_from_double: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(pending && fault_ev));
  a_r9_halt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(halt_en));
endmodule

bind bushalt_mon bushalt_mon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .halt(halt), .busy(busy_w),
  .cyc_ack(cyc_ack), .halt_en(cfg_q.halt_en), .bm_en(cfg_q.bm_en),
  .tsel(cfg_q.tsel), .bm_lock(bm_lock), .tsel_lock(tsel_lock),
  .pending(pending_w), .fault_ev(fault_ev_w)
);

// File: tb/bushalt_mon_tb.sv
module bushalt_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_start, cyc_ext, cyc_ack, bus_fault;
  logic [2:0] cfg_wr_sel;
  logic [3:0] cfg_wdata;
  logic       bus_err, halt;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  bushalt_mon dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_ext(cyc_ext),
    .cyc_ack(cyc_ack), .bus_fault(bus_fault), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wdata(cfg_wdata), .bus_err(bus_err), .halt(halt)
  );

  // Vector table: period code, ext flag, monitor enable, ack edge (0 = none), expected error edge (0 = none)
  localparam int NV = 9;
  localparam int V_TSEL[NV] = '{0, 1, 2, 3, 3, 3, 2, 3, 3};
  localparam int V_EXT [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_BM  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int V_ACK [NV] = '{0, 0, 0, 0, 8, 7, 20, 0, 0};
  localparam int V_EXP [NV] = '{64, 32, 16, 8, 0, 0, 16, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc_start = 0; cyc_ext = 0; cyc_ack = 0; bus_fault = 0;
    cfg_wr_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [3:0] d);
    cfg_wr_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_sel = '0;
  endtask

  // Returns the edge count (after the start edge) at which bus_err was first seen.
  task automatic run_cycle(input int ack_d, input logic ext, output int err_at);
    cyc_start = 1'b1; cyc_ext = ext;
    @(negedge clk);
    cyc_start = 1'b0; cyc_ext = 1'b0;
    err_at = 0;
    for (int k = 1; k <= 80; k++) begin
      if (k == ack_d) cyc_ack = 1'b1;
      @(negedge clk);
      cyc_ack = 1'b0;
      if (bus_err && err_at == 0) err_at = k;
    end
  endtask

  task automatic pulse_fault();
    bus_fault = 1'b1;
    @(negedge clk);
    bus_fault = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e;
    do_reset();
    check("R10 bus_err after reset", int'(bus_err), 0);
    check("R10 halt after reset", int'(halt), 0);

    // R1 R2 R3 R4: table walk, one reset per vector
    for (int i = 0; i < NV; i++) begin
      do_reset();
      cfg_write(3'b110, {2'(V_TSEL[i]), 1'(V_BM[i]), 1'b0});
      run_cycle(V_ACK[i], 1'(V_EXT[i]), e);
      check($sformatf("R1/R2/R4 vector %0d error edge", i), e, V_EXP[i]);
      check($sformatf("R3 vector %0d err low after pulse", i), int'(bus_err), 0);
    end

    // R10: period code defaults to 00 (64 clocks)
    do_reset();
    cfg_write(3'b010, 4'b0010);
    run_cycle(0, 1'b1, e);
    check("R10 default period", e, 64);

    // R5: enable written 0 first, later write of 1 ignored
    do_reset();
    cfg_write(3'b110, 4'b1100);
    cfg_write(3'b010, 4'b0010);
    run_cycle(0, 1'b1, e);
    check("R5 enable rewrite ignored", e, 0);

    // R6: period locked separately; enable's first write still taken
    do_reset();
    cfg_write(3'b100, 4'b1100);
    cfg_write(3'b100, 4'b0000);
    cfg_write(3'b010, 4'b0010);
    run_cycle(0, 1'b1, e);
    check("R6 period rewrite ignored", e, 8);

    // R1: start ignored while a timed cycle runs
    do_reset();
    cfg_write(3'b110, 4'b1110);
    cyc_start = 1'b1; cyc_ext = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    cyc_start = 1'b0; cyc_ext = 1'b0;
    e = 0;
    for (int k = 4; k <= 20; k++) begin
      @(negedge clk);
      if (bus_err && e == 0) e = k;
    end
    check("R1 restart ignored while busy", e, 8);

    // R8: timeout then external fault with halt enabled
    do_reset();
    cfg_write(3'b111, 4'b1111);
    run_cycle(0, 1'b1, e);
    check("R8 first fault is timeout", e, 8);
    check("R8 no halt after one fault", int'(halt), 0);
    pulse_fault();
    check("R8 halt on double fault", int'(halt), 1);
    cyc_ack = 1'b1; @(negedge clk); cyc_ack = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 halt sticky", int'(halt), 1);

    // R9 R7: halt disabled keeps pending; enabling later halts on next fault
    do_reset();
    pulse_fault();
    pulse_fault();
    check("R9 no halt while disabled", int'(halt), 0);
    cfg_write(3'b001, 4'b0001);
    pulse_fault();
    check("R7 halt after late enable", int'(halt), 1);

    // R9: clean ack clears the pending fault
    do_reset();
    cfg_write(3'b001, 4'b0001);
    pulse_fault();
    cyc_ack = 1'b1; @(negedge clk); cyc_ack = 1'b0;
    pulse_fault();
    check("R9 ack clears pending", int'(halt), 0);
    pulse_fault();
    check("R8 halt after new double fault", int'(halt), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule